// File: doc/BRIEF.md
# Pixel Clock Program Word Calculator

This block turns a requested pixel clock period, given in picoseconds, into the 16-bit word that a serially loaded frequency synthesizer expects. A one-cycle `start` strobe captures the period. A sequential state machine then works through the calculation. First it derives the frequency in units of 0.01 MHz with a restoring shift-subtract divider. Next it checks that frequency against the supported range. It then doubles the frequency into the oscillator band, keeping track of the post-divider as it goes. A second division gives the feedback count and a third rounds it. Finally the feedback count, a post-divider code and fixed stop bits are packed into the word.

The result appears together with a one-cycle `done` pulse and stays stable until the next accepted request. Requests that fall outside the supported range finish with `err` set and a zero word. Shifting the word out to the synthesizer is handled elsewhere.

Top module: `pclk_word_calc`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, and `word` and `post_div` are zero.
- R2: The frequency F is floor(100000000 / period_ps). F = 15938 is accepted. Any F above 15938 ends the request with `err` high.
- R3: Any F below 1000 ends the request with `err` high. F = 1000 is accepted.
- R4: A period of zero ends the request with `err` high and starts no division.
- R5: While F < 8000, F is doubled and the post-divider, which starts at 1, is doubled too. `post_div` reports the final value: 1, 2, 4 or 8.
- R6: The feedback count is N = ((46 * F * 1000) / 1432 + 500) / 1000, where every division truncates. The low bits of `word` hold N - 257.
- R7: The post-divider code sits in word bits 10:9. It is 2'b11 for a post-divider of 1, 2'b10 for 2, 2'b01 for 4 and 2'b00 for 8.
- R8: On every successful result, word bits 12:11 are both 1.
- R9: When a request fails, `word` and `post_div` are zero when `done` pulses.
- R10: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted start through the `done` cycle, and low in the cycle after it.
- R11: A `start` that arrives while `busy` is high is ignored, and the result belongs to the earlier request.
- R12: `word`, `post_div` and `err` hold their values after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted only while idle |
| period_ps | input | 32 | Requested pixel clock period in picoseconds |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | The last request was rejected |
| word | output | 16 | Synthesizer program word |
| post_div | output | 4 | Chosen post-divider (1, 2, 4 or 8) |

## Verification
The assertions take for granted that `start` is a single-cycle strobe and that `period_ps` is stable in the cycle where `start` is sampled. They also take for granted that only the outcome at `done` matters, not intermediate cycles. The stimulus drives inputs on the falling edge and raises `start` for exactly one cycle. It then waits for `done` before issuing the next request, except in the one scenario that deliberately strobes `start` while the block is busy. The chosen periods sit on each range boundary and inside each post-divider band, so that every value of the code field appears.

// File: rtl/pclk_word_pkg.sv
package pclk_word_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_RANGE,
    ST_SCALE,
    ST_FBDIV,
    ST_ROUND,
    ST_FIN
  } calc_state_t;

  function automatic logic [1:0] post_code(input logic [3:0] post);
    case (post)
      4'd1:    post_code = 2'b11;
      4'd2:    post_code = 2'b10;
      4'd4:    post_code = 2'b01;
      default: post_code = 2'b00;
    endcase
  endfunction

  function automatic logic [15:0] pack_word(input logic [15:0] fb,
                                            input logic [15:0] bias,
                                            input logic [3:0]  post,
                                            input logic [15:0] stop_bits);
    logic [15:0] base;
    base = fb - bias;
    pack_word = base | {5'd0, post_code(post), 9'd0} | stop_bits;
  endfunction

endpackage

// File: rtl/pclk_divider.sv
module pclk_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted;
  logic          fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign fits    = shifted >= {1'b0, divisor};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fits) rem_q <= W'(shifted - {1'b0, divisor});
        else      rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;
endmodule

// File: rtl/pclk_word_pack.sv
module pclk_word_pack #(
  parameter logic [15:0] BIAS      = 16'd257,
  parameter logic [15:0] STOP_BITS = 16'h1800
) (
  input  logic [15:0] fb,
  input  logic [3:0]  post,
  output logic [15:0] word
);
  import pclk_word_pkg::*;
  assign word = pack_word(fb, BIAS, post, STOP_BITS);
endmodule

// File: rtl/pclk_word_calc.sv
module pclk_word_calc #(
  parameter int          W         = 32,
  parameter int          NUMERATOR = 100000000,
  parameter int          F_MAX     = 15938,
  parameter int          F_MIN     = 1000,
  parameter int          F_VCO_LOW = 8000,
  parameter int          REF_MUL   = 46,
  parameter int          REF_FREQ  = 1432,
  parameter int          SCALE     = 1000,
  parameter logic [15:0] BIAS      = 16'd257,
  parameter logic [15:0] STOP_BITS = 16'h1800
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [31:0]  period_ps,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [15:0]  word,
  output logic [3:0]   post_div
);
  import pclk_word_pkg::*;

  localparam logic [W-1:0] FB_MUL = W'(REF_MUL * SCALE);
  localparam logic [W-1:0] HALF   = W'(SCALE / 2);

  calc_state_t  st_q;
  logic [W-1:0] freq_q;
  logic [3:0]   post_q;
  logic         dv_go;
  logic [W-1:0] dv_a, dv_b;
  logic         dv_fin;
  logic [W-1:0] dv_q;
  logic [15:0]  packed_word;
  logic         req_accept;
  logic         out_of_range;

  assign req_accept   = start && (st_q == ST_IDLE);
  assign out_of_range = (freq_q > W'(F_MAX)) || (freq_q < W'(F_MIN));

  pclk_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(dv_go),
    .dividend(dv_a), .divisor(dv_b),
    .fin(dv_fin), .quotient(dv_q)
  );

  pclk_word_pack #(.BIAS(BIAS), .STOP_BITS(STOP_BITS)) u_pack (
    .fb(dv_q[15:0]), .post(post_q), .word(packed_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      freq_q   <= '0;
      post_q   <= 4'd1;
      dv_go    <= 1'b0;
      dv_a     <= '0;
      dv_b     <= '0;
      err      <= 1'b0;
      word     <= '0;
      post_div <= '0;
    end else begin
      dv_go <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_accept) begin
          err      <= 1'b0;
          word     <= '0;
          post_div <= '0;
          post_q   <= 4'd1;
          if (period_ps == '0) begin
            err  <= 1'b1;
            st_q <= ST_FIN;
          end else begin
            dv_a  <= W'(NUMERATOR);
            dv_b  <= W'(period_ps);
            dv_go <= 1'b1;
            st_q  <= ST_FREQ;
          end
        end
        ST_FREQ: if (dv_fin) begin
          freq_q <= dv_q;
          st_q   <= ST_RANGE;
        end
        ST_RANGE: begin
          if (out_of_range) begin
            err  <= 1'b1;
            st_q <= ST_FIN;
          end else begin
            st_q <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          if (freq_q < W'(F_VCO_LOW)) begin
            freq_q <= freq_q << 1;
            post_q <= post_q << 1;
          end else begin
            dv_a  <= freq_q * FB_MUL;
            dv_b  <= W'(REF_FREQ);
            dv_go <= 1'b1;
            st_q  <= ST_FBDIV;
          end
        end
        ST_FBDIV: if (dv_fin) begin
          dv_a  <= dv_q + HALF;
          dv_b  <= W'(SCALE);
          dv_go <= 1'b1;
          st_q  <= ST_ROUND;
        end
        ST_ROUND: if (dv_fin) begin
          word     <= packed_word;
          post_div <= post_q;
          st_q     <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_FIN);
endmodule

// File: rtl/pclk_word_calc_chk.sv
module pclk_word_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [15:0] word,
  input logic [3:0]  post_div
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R10
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R11
  AST_POST_POW2: assert property (@(posedge clk) disable iff (!rst_n) (done && !err) |-> ($countones(post_div) == 1)); // R5
  AST_STOP_BITS: assert property (@(posedge clk) disable iff (!rst_n) (done && !err) |-> (word[12:11] == 2'b11)); // R8
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> (word == 16'd0 && post_div == 4'd0)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> ($stable(word) && $stable(err))); // R12
endmodule

bind pclk_word_calc pclk_word_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .word(word), .post_div(post_div)
);

// File: tb/tb_pclk_word_calc.sv
`timescale 1ns/1ps
module tb_pclk_word_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] period_ps = '0;
  logic        busy, done, err;
  logic [15:0] word;
  logic [3:0]  post_div;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pclk_word_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
    .busy(busy), .done(done), .err(err), .word(word), .post_div(post_div)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input longint p, output bit e, output longint w, output longint pd);
    longint f, n, code;
    e = 0; w = 0; pd = 0;
    if (p == 0) begin e = 1; return; end
    f = 100000000 / p;
    if (f > 15938 || f < 1000) begin e = 1; return; end
    pd = 1;
    while (f < 8000) begin f = f * 2; pd = pd * 2; end
    n = ((46 * f * 1000) / 1432 + 500) / 1000;
    code = (pd == 1) ? 'h600 : (pd == 2) ? 'h400 : (pd == 4) ? 'h200 : 0;
    w = ((n - 257) & 'hFFFF) | code | 'h1800;
  endtask

  task automatic pulse_start(input logic [31:0] p);
    @(negedge clk);
    period_ps = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin got = 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic run_case(input string req, input logic [31:0] p);
    bit e, got;
    longint w, pd;
    model(p, e, w, pd);
    pulse_start(p);
    check({req, " busy after start R10"}, busy | done, 1);
    wait_done(got);
    check({req, " done seen R10"}, got, 1);
    check({req, " err"}, err, e);
    check({req, " word R6 R7 R8 R9"}, word, w);
    check({req, " post_div R5"}, post_div, pd);
    @(negedge clk);
    check({req, " done single R10"}, done, 0);
    check({req, " busy low R10"}, busy, 0);
    repeat (3) @(negedge clk);
    check({req, " hold word R12"}, word, w);
    check({req, " hold err R12"}, err, e);
  endtask

  task automatic test_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 word", word, 0);
    check("R1 post_div", post_div, 0);
  endtask

  task automatic test_busy_ignore();
    bit e, got;
    longint w, pd;
    model(39722, e, w, pd);
    pulse_start(39722);
    repeat (5) @(negedge clk);
    period_ps = 6274;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    check("R11 done", got, 1);
    check("R11 word of first request", word, w);
    check("R11 post of first request", post_div, pd);
    @(negedge clk);
    check("R11 idle after", busy, 0);
  endtask

  initial begin
    bit finished = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_case("R6 F=8000 post1", 12500);
        run_case("R5 F=7999 post2", 12501);
        run_case("R5 R7 post4", 39722);
        run_case("R3 F=1000 post8", 100000);
        run_case("R2 F=15938 upper edge", 6274);
        run_case("R2 above upper", 6273);
        run_case("R3 below lower", 100001);
        run_case("R4 zero period", 0);
        run_case("R6 mid band", 15000);
        test_busy_ignore();
        finished = 1;
      end
      begin
        repeat (100000) @(negedge clk);
      end
    join_any
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule